// File: doc/BRIEF.md
# Programmable interrupt source router

This block sits between the interrupt request lines of many peripherals and the nine general-purpose request inputs of a core event controller. Those inputs carry priority levels 7 to 15. Every peripheral source has its own assignment field that names the level it feeds. It also has an enable bit, so that software can silence the source before it reaches any level. When several enabled sources are assigned to the same level, their requests are combined into one request for that level. The block registers its nine level outputs, so they change only on a clock edge and never glitch.

Software reaches the router through a simple word-addressed register port. Writes take effect on the clock edge, and reads return data combinationally. After reset every source is disabled. The assignment fields start from a built-in map:
- the wakeup source and the error sources go to the highest general level;
- the clock-calendar source and the first data-mover channel go to the next level;
- the serial-port data-mover channels go to the level after that;
- the remaining sources go to the lowest level.

A status word shows the raw source lines, whatever the enables hold. The router makes no choice between levels. Priority arbitration is left to the event controller that reads its outputs.

Top module: `irq_router`

## Requirements
- R1: After reset, `lvl_irq` is all zero and the enable word (word address 4) reads all zero, which means every source is disabled.
- R2: After reset, the assignment words at addresses 0 to 3 read back the default map. Source s uses bits [4*(s%8)+3 : 4*(s%8)] of word s/8. Sources 0 to 15 hold field 0, sources 16 and 17 hold field 1, sources 18 to 22 hold field 2, and sources 23 to 31 hold field 8.
- R3: A source with enable bit s (bit s of word 4) set and an assignment field k in the range 0 to 8 drives `lvl_irq[k]`, which is level 7+k. `lvl_irq` shows the source, enable and assignment values that were present just before the previous rising clock edge.
- R4: A source whose assignment field is 9 to 15 drives no output bit.
- R5: Each `lvl_irq[k]` is the OR of every enabled, asserted source whose field equals k.
- R6: A source whose enable bit is clear has no effect on `lvl_irq`.
- R7: Word address 5 reads the raw `src_irq` lines, whatever the enable bits hold.
- R8: A write to word address 5, 6 or 7 changes no register. Reads of addresses 6 and 7 return zero.
- R9: A write to an assignment or enable word changes `lvl_irq` on the second rising edge after the write is presented: the first edge loads the register and the second edge loads the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Peripheral interrupt request lines, active high |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lvl_irq | output | 9 | Registered requests; bit k drives priority level 7+k |

## Verification
On every cycle, the assertions check four things: a fully disabled router or a silent source set gives quiet outputs on the next edge; any output request is traced back to an enabled, asserted source; the status word mirrors the raw lines; and unmapped addresses read zero. Only the bench scenarios can show that the reset map is correct and that each field value selects exactly one level, or none for values 9 to 15. The same is true of the OR-merging of shared levels, the one-edge output latency, and writes to read-only or unmapped words being dropped. These properties depend on particular configurations compared against a reference model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   // Default assignment field for a source index at reset.
   // Wakeup and error sources -> field 0, clock-calendar and first data
   // mover -> field 1, serial-port movers -> field 2, all others -> field 8.
   function automatic int unsigned default_field(int unsigned src_idx);
      if (src_idx < 16)      return 0;
      else if (src_idx < 18) return 1;
      else if (src_idx < 23) return 2;
      else                   return 8;
   endfunction

endpackage

// File: rtl/irq_router_cfg.sv
module irq_router_cfg #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [NUM_SRC-1:0]         raw_src,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_SRC*FIELD_W-1:0] fld_flat,
   output logic [NUM_SRC-1:0]         en_mask
);
   localparam int unsigned FPR     = DATA_W / FIELD_W;
   localparam int unsigned NREG    = NUM_SRC / FPR;
   localparam int unsigned EN_ADDR = NREG;
   localparam int unsigned ST_ADDR = NREG + 1;

   if (NUM_SRC % FPR != 0) begin : g_bad_pack
      $error("NUM_SRC must fill whole assignment words");
   end
   if (NUM_SRC > DATA_W) begin : g_bad_en
      $error("enable and status words must fit in one data word");
   end
   if (ST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   // Assignment fields, one register per source.
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_flat[s*FIELD_W +: FIELD_W] <= FIELD_W'(irq_router_pkg::default_field(s));
         else if (wr_en && addr == ADDR_W'(s / FPR))
            fld_flat[s*FIELD_W +: FIELD_W] <= wdata[(s % FPR)*FIELD_W +: FIELD_W];
      end
   end

   // Enable word, all sources disabled at reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_mask <= '0;
      else if (wr_en && addr == ADDR_W'(EN_ADDR))
         en_mask <= wdata[NUM_SRC-1:0];
   end

   // Combinational read mux.
   always_comb begin
      rdata = '0;
      for (int unsigned r = 0; r < NREG; r++) begin
         if (addr == ADDR_W'(r))
            rdata = fld_flat[r*DATA_W +: DATA_W];
      end
      if (addr == ADDR_W'(EN_ADDR))
         rdata[NUM_SRC-1:0] = en_mask;
      if (addr == ADDR_W'(ST_ADDR))
         rdata[NUM_SRC-1:0] = raw_src;
   end

endmodule

// File: rtl/irq_router_matrix.sv
module irq_router_matrix #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned NUM_LVL = 9
) (
   input  logic [NUM_SRC-1:0]         src,
   input  logic [NUM_SRC-1:0]         en_mask,
   input  logic [NUM_SRC*FIELD_W-1:0] fld_flat,
   output logic [NUM_LVL-1:0]         lvl_hit
);
   if ((1 << FIELD_W) < NUM_LVL) begin : g_bad_field
      $error("FIELD_W cannot encode every level");
   end

   logic [NUM_SRC-1:0] gated;
   logic [NUM_LVL-1:0][NUM_SRC-1:0] sel;

   assign gated = src & en_mask;

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign sel[l][s] = (fld_flat[s*FIELD_W +: FIELD_W] == FIELD_W'(l));
      end
      assign lvl_hit[l] = |(sel[l] & gated);
   end

endmodule

// File: rtl/irq_router.sv
module irq_router #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_irq,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_LVL-1:0] lvl_irq
);
   logic [NUM_SRC*FIELD_W-1:0] fld_flat;
   logic [NUM_SRC-1:0]         en_mask;
   logic [NUM_LVL-1:0]         lvl_hit;

   irq_router_cfg #(
      .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .raw_src(src_irq), .rdata(bus_rdata),
      .fld_flat(fld_flat), .en_mask(en_mask)
   );

   irq_router_matrix #(
      .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_LVL(NUM_LVL)
   ) mtx_i (
      .src(src_irq), .en_mask(en_mask), .fld_flat(fld_flat), .lvl_hit(lvl_hit)
   );

   // Registered outputs: glitch-free toward the event controller.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_irq <= '0;
      else        lvl_irq <= lvl_hit;
   end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned NUM_LVL = 9,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_irq,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_SRC-1:0] en_mask,
   input logic [NUM_LVL-1:0] lvl_irq
);
   localparam int unsigned ST_ADDR = NUM_SRC / (DATA_W / FIELD_W) + 1;

   // R6: nothing enabled -> outputs quiet after the next edge
   a_r6_all_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mask == '0) |=> (lvl_irq == '0));

   // R5: no source asserted -> outputs quiet after the next edge
   a_r5_no_source_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (src_irq == '0) |=> (lvl_irq == '0));

   // R3: any request must come from an enabled, asserted source
   a_r3_request_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_irq != '0) |-> $past(|(src_irq & en_mask)));

   // R7: status word mirrors raw lines
   a_r7_status_raw: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ST_ADDR)) |-> (bus_rdata[NUM_SRC-1:0] == src_irq));

   // R8: unmapped addresses read zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(ST_ADDR)) |-> (bus_rdata == '0));

endmodule

bind irq_router irq_router_chk #(
   .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_LVL(NUM_LVL),
   .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .en_mask(en_mask), .lvl_irq(lvl_irq)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_irq = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [8:0]  lvl_irq;

   int vec_cnt = 0;
   int err_cnt = 0;

   logic [3:0]  fld_m [32];
   logic [31:0] en_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_router dut_i (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .lvl_irq(lvl_irq)
   );

   function automatic logic [3:0] dflt(int s);
      if (s < 16) return 4'd0;
      if (s < 18) return 4'd1;
      if (s < 23) return 4'd2;
      return 4'd8;
   endfunction

   function automatic logic [8:0] exp_lvl(logic [31:0] src);
      logic [8:0] r = '0;
      for (int s = 0; s < 32; s++)
         if (src[s] && en_m[s] && fld_m[s] <= 4'd8) r[fld_m[s]] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] exp_word(int w);
      logic [31:0] r = '0;
      for (int i = 0; i < 8; i++) r[i*4 +: 4] = fld_m[w*8 + i];
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         err_cnt++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at a negedge.
   task automatic wr(logic [2:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      if (a < 3'd4)
         for (int i = 0; i < 8; i++) fld_m[a*8 + i] = d[i*4 +: 4];
      else if (a == 3'd4)
         en_m = d;
   endtask

   task automatic rd_check(string req, logic [2:0] a, logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic settle();
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic lvl_check(string req, logic [31:0] src);
      src_irq = src;
      settle();
      check(req, {23'd0, lvl_irq}, {23'd0, exp_lvl(src)});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      err_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

   initial begin
      logic [31:0] prev;
      void'($urandom(32'h1F2E3D4C));
      for (int s = 0; s < 32; s++) fld_m[s] = dflt(s);
      en_m = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 out", {23'd0, lvl_irq}, 32'd0);
      rd_check("R1 enable", 3'd4, 32'd0);
      // R2 default map
      for (int w = 0; w < 4; w++) rd_check("R2 default word", 3'(w), exp_word(w));
      // R6: disabled sources ignored
      lvl_check("R6 all disabled", 32'hFFFF_FFFF);

      // R3 default routing of each source
      wr(3'd4, 32'hFFFF_FFFF);
      for (int s = 0; s < 32; s++) lvl_check("R3 default route", 32'd1 << s);

      // R3 every field value 0..8 selects its level
      for (int k = 0; k < 9; k++) begin
         wr(3'd0, {28'd0, 4'(k)});
         lvl_check("R3 field select", 32'd1);
      end

      // R4 fields 9..15 route nowhere
      wr(3'd0, 32'hFEDC_BA99);
      lvl_check("R4 disabled field", 32'h0000_00FF);

      // R5 shared level is an OR
      wr(3'd1, 32'h3333_3333);
      lvl_check("R5 OR one source", 32'h0000_0100);
      lvl_check("R5 OR many", 32'h0000_FF00);
      lvl_check("R5 OR mixed", 32'hF0F0_0F00);

      // R6 selective enable
      wr(3'd4, 32'h0000_00F0);
      lvl_check("R6 partial mask", 32'hFFFF_FFFF);

      // R7 status raw regardless of mask
      src_irq = 32'hA5A5_5A5A; rd_check("R7 status", 3'd5, 32'hA5A5_5A5A);
      wr(3'd4, 32'd0);
      src_irq = 32'h1234_8765; rd_check("R7 status masked", 3'd5, 32'h1234_8765);

      // R8 read-only and unmapped writes dropped
      wr(3'd5, 32'hDEAD_BEEF);
      rd_check("R8 status write ignored", 3'd5, 32'h1234_8765);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      for (int w = 0; w < 4; w++) rd_check("R8 assign untouched", 3'(w), exp_word(w));
      rd_check("R8 enable untouched", 3'd4, 32'd0);
      rd_check("R8 unmapped read 6", 3'd6, 32'd0);
      rd_check("R8 unmapped read 7", 3'd7, 32'd0);

      // R9 / R3 timing: enable write reaches the output on the second edge
      src_irq = 32'h0000_0001;
      wr(3'd0, 32'd0);
      prev = {23'd0, lvl_irq};
      bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; en_m = 32'h1;
      check("R9 after first edge", {23'd0, lvl_irq}, prev);
      @(posedge clk); @(negedge clk);
      check("R9 after second edge", {23'd0, lvl_irq}, 32'h1);
      // R3 one-edge latency from source
      src_irq = 32'd0;
      #1;
      check("R3 before edge", {23'd0, lvl_irq}, 32'h1);
      @(posedge clk); @(negedge clk);
      check("R3 after edge", {23'd0, lvl_irq}, 32'h0);

      // Constrained random mix
      for (int it = 0; it < 400; it++) begin
         if ($urandom_range(0, 2) == 0) begin
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic [31:0] d = $urandom;
            if (a == 3'd4 && $urandom_range(0, 1) == 1) d = 32'hFFFF_FFFF;
            wr(a, d);
            if (a < 3'd4) rd_check("R2 random readback", a, exp_word(int'(a)));
         end
         lvl_check("R5 random route", $urandom);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

endmodule